// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Byte Memory Controller

This block is the device-side controller of a byte-wide nonvolatile memory that a host drives with ordinary static-RAM strobes: active-low chip select, output enable and write enable, plus an address bus and a data bus. Reads return stored bytes one clock after they are sampled. Writes do not reach storage directly. Each accepted write strobe captures its address and data into a page register, so the host can release the buses as soon as the strobe ends.

The first accepted byte fixes the page: the upper address bits name it and the low `PAGE_BITS` bits pick the byte inside it. Further bytes for the same page may follow. Once a set number of clocks passes after the last accepted strobe with no new one, an internal timer runs the commit. At the end of that timer, every loaded byte is written into the storage array in one step. Bytes that were not loaded keep their old values.

While the commit runs, the block ignores write strobes. During that time a read returns a status byte whose top bit is the inverse of the top bit of the last byte loaded. A host polls that bit until it matches the data it wrote, and then goes on. The storage is an on-chip register array whose depth is set by a parameter. The default is kept small, and setting `ADDR_W` to 15 gives a 32K-byte part.

Top module: `pagecommit_eeprom`

## Requirements
- R1: After reset, `dout` is 0, `dout_en` is 0, the engine is idle and every array location reads back as 0.
- R2: A clock edge that samples `ce_n`=0, `oe_n`=0 and `we_n`=1 while no commit runs makes `dout` equal the array byte at `addr` and `dout_en` 1 after that edge. An edge that samples any other combination drives `dout` and `dout_en` to 0 after that edge.
- R3: A write strobe is the first edge at which `ce_n` and `we_n` are both 0. It does not matter what `oe_n` is. The strobe loads `din` into byte `addr[PAGE_BITS-1:0]` of the page register. A strobe held low over several edges loads only the data of its first edge.
- R4: The first accepted strobe fixes the page to `addr[ADDR_W-1:PAGE_BITS]`. A later strobe whose page differs is ignored: it loads no byte, it does not change the polled bit and it does not restart the load window.
- R5: The commit begins `LOAD_WIN` edges after the last accepted strobe edge. Reads sampled up to and including that edge return the old array data.
- R6: The commit lasts `WRITE_MS*CLK_KHZ` edges. If the last accepted strobe is at edge E, reads sampled at edges E+LOAD_WIN+1 through E+LOAD_WIN+WRITE_MS*CLK_KHZ return the polling status. A read sampled at the next edge returns the new data.
- R7: The polling status is a byte whose top bit is the inverse of the top bit of the last accepted byte, with all lower bits 0.
- R8: The commit writes every loaded byte of the page into the array at once. Bytes of that page that were not loaded, and all other pages, keep their contents.
- R9: Write strobes sampled while a commit runs load nothing and start no later commit.
- R10: When the same byte position is loaded twice within one page load, the later value is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address; upper bits select the page |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or polling status, registered |
| dout_en | output | 1 | High when `dout` carries a read result |

## Verification
A read result appears one edge after the read is sampled. So the bench drives each read at a falling edge and compares `dout` at the next falling edge. Writes are paced at one strobe every two edges. The bench counts edges from the last accepted strobe E. From that count it places reads at E+2 and E+LOAD_WIN, which must show old data, and at E+LOAD_WIN+1 and E+LOAD_WIN+WRITE_MS*CLK_KHZ, which must show the polling byte. The read at the edge after that must show the new byte. These placements let an off-by-one in either timer show up as a mismatch. Ignored strobes, whether from a page mismatch or from arriving during a commit, are checked in two ways: by what the affected locations read back after a full commit time, and by the poll arriving on its unshifted edge.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_COMMIT = 2'd2
    } phase_e;

endpackage

// File: rtl/pc_countdown.sv
// Loadable down counter that stops at zero; zero flags the terminal count.
module pc_countdown #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          en,
    output logic          zero
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (en && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q.cnt == '0);

endmodule

// File: rtl/pc_page_buf.sv
// Page register: one data byte and one valid flag per byte position.
module pc_page_buf #(
    parameter int unsigned PAGE_BITS = 6,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned PAGE_BYTES = 1 << PAGE_BITS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load,
    input  logic [PAGE_BITS-1:0]                idx,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic                                clear,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]   buf_data,
    output logic [PAGE_BYTES-1:0]               buf_valid
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]             valid;
    } pbuf_t;

    pbuf_t pb_q, pb_d;

    always_comb begin
        pb_d = pb_q;
        if (clear) begin
            pb_d.valid = '0;
        end else if (load) begin
            pb_d.data[idx]  = wdata;
            pb_d.valid[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q <= '0;
        end else begin
            pb_q <= pb_d;
        end
    end

    assign buf_data  = pb_q.data;
    assign buf_valid = pb_q.valid;

endmodule

// File: rtl/pc_array.sv
// Storage array; a commit writes every valid page-register byte in one edge.
module pc_array #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned PAGE_BITS = 6,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned DEPTH      = 1 << ADDR_W,
    localparam int unsigned PAGE_BYTES = 1 << PAGE_BITS,
    localparam int unsigned PG_W       = ADDR_W - PAGE_BITS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                commit,
    input  logic [PG_W-1:0]                     cpage,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0]   cdata,
    input  logic [PAGE_BYTES-1:0]               cvalid,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } store_t;

    store_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            for (int b = 0; b < int'(PAGE_BYTES); b++) begin
                if (cvalid[b]) begin
                    st_d.mem[{cpage, PAGE_BITS'(b)}] = cdata[b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[rd_addr];

endmodule

// File: rtl/pagecommit_eeprom.sv
module pagecommit_eeprom
    import pc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned PAGE_BITS = 6,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned LOAD_WIN  = 32,
    parameter int unsigned WRITE_MS  = 3,
    parameter int unsigned CLK_KHZ   = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int unsigned PAGE_BYTES = 1 << PAGE_BITS;
    localparam int unsigned PG_W       = ADDR_W - PAGE_BITS;
    localparam int unsigned COMMIT_CYC = WRITE_MS * CLK_KHZ;
    localparam int unsigned WIN_W      = $clog2(LOAD_WIN + 1);
    localparam int unsigned CYC_W      = $clog2(COMMIT_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [PG_W-1:0]   page;
        logic              msb;
        logic              wr_act;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic                              wr_lvl, wr_stb, rd_lvl, accept;
    logic [PG_W-1:0]                   page_in;
    logic                              win_zero, cmt_zero, win_load, cmt_load;
    logic                              commit_busy, commit_fire, held_msb;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] pg_data;
    logic [PAGE_BYTES-1:0]             pg_valid;
    logic [DATA_W-1:0]                 arr_rdata;

    assign wr_lvl  = !ce_n && !we_n;
    assign wr_stb  = wr_lvl && !ctl_q.wr_act;
    assign rd_lvl  = !ce_n && !oe_n && we_n;
    assign page_in = addr[ADDR_W-1:PAGE_BITS];

    assign commit_busy = (ctl_q.phase == PH_COMMIT);
    assign commit_fire = commit_busy && cmt_zero;
    assign held_msb    = ctl_q.msb;

    assign accept = wr_stb && ((ctl_q.phase == PH_IDLE) ||
                               ((ctl_q.phase == PH_LOAD) && (page_in == ctl_q.page)));

    assign win_load = accept;
    assign cmt_load = (ctl_q.phase == PH_LOAD) && !accept && win_zero;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.wr_act = wr_lvl;

        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    ctl_d.phase = PH_LOAD;
                    ctl_d.page  = page_in;
                end
            end
            PH_LOAD: begin
                if (cmt_load) begin
                    ctl_d.phase = PH_COMMIT;
                end
            end
            PH_COMMIT: begin
                if (cmt_zero) begin
                    ctl_d.phase = PH_IDLE;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase

        if (accept) begin
            ctl_d.msb = din[DATA_W-1];
        end

        if (rd_lvl) begin
            ctl_d.rvalid = 1'b1;
            if (commit_busy) begin
                ctl_d.rdata = {!ctl_q.msb, {(DATA_W-1){1'b0}}};
            end else begin
                ctl_d.rdata = arr_rdata;
            end
        end else begin
            ctl_d.rvalid = 1'b0;
            ctl_d.rdata  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dout    = ctl_q.rdata;
    assign dout_en = ctl_q.rvalid;

    pc_countdown #(.CW(WIN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (WIN_W'(LOAD_WIN - 1)),
        .en       (ctl_q.phase == PH_LOAD),
        .zero     (win_zero)
    );

    pc_countdown #(.CW(CYC_W)) u_cmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmt_load),
        .load_val (CYC_W'(COMMIT_CYC - 1)),
        .en       (commit_busy),
        .zero     (cmt_zero)
    );

    pc_page_buf #(.PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .idx       (addr[PAGE_BITS-1:0]),
        .wdata     (din),
        .clear     (commit_fire),
        .buf_data  (pg_data),
        .buf_valid (pg_valid)
    );

    pc_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit_fire),
        .cpage   (ctl_q.page),
        .cdata   (pg_data),
        .cvalid  (pg_valid),
        .rd_addr (addr),
        .rd_data (arr_rdata)
    );

endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              busy,
    input logic              fire,
    input logic              last_msb
);

    a_r2_read_enables_output: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dout_en);

    a_r2_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && !oe_n && we_n) |=> (!dout_en && (dout == '0)));

    a_r7_poll_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && busy) |=>
            (dout == {!$past(last_msb), {(DATA_W-1){1'b0}}}));

    a_r6_busy_until_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fire) |=> busy);

    a_r6_fire_ends_commit: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !busy);

    a_r9_msb_frozen_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(last_msb));

endmodule

bind pagecommit_eeprom pc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dout     (dout),
    .dout_en  (dout_en),
    .busy     (commit_busy),
    .fire     (commit_fire),
    .last_msb (held_msb)
);

// File: tb/sim_pagecommit_eeprom.sv
module sim_pagecommit_eeprom;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int PB   = 4;
    localparam int WIN  = 4;
    localparam int WMS  = 3;
    localparam int KHZ  = 6;
    localparam int CMT  = WMS * KHZ;
    localparam int NPG  = 1 << PB;
    localparam int DEP  = 1 << AW;
    localparam int WDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [7:0] exp_mem [DEP];
    logic [7:0] pend_val [NPG];
    logic       pend_vld [NPG];
    int         pend_page;

    always #(CLK_PERIOD/2) clk = ~clk;

    pagecommit_eeprom #(
        .ADDR_W(AW), .PAGE_BITS(PB), .DATA_W(8),
        .LOAD_WIN(WIN), .WRITE_MS(WMS), .CLK_KHZ(KHZ)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): cycles=%0d expected below %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 37 + salt * 11 + 5) & 255);
    endfunction

    // Called at a falling edge; strobe is sampled at the next rising edge (E),
    // returns at the falling edge after E+1.
    task automatic do_write(input int a, input logic [7:0] d, input bit take);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        addr = AW'(a); din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        if (take) begin
            pend_page = a >> PB;
            pend_val[a % NPG] = d;
            pend_vld[a % NPG] = 1'b1;
        end
    endtask

    task automatic apply_pending();
        for (int b = 0; b < NPG; b++) begin
            if (pend_vld[b]) exp_mem[pend_page * NPG + b] = pend_val[b];
            pend_vld[b] = 1'b0;
        end
    endtask

    // Called at a falling edge; read sampled at next rising edge.
    task automatic read_now(input int a, output logic [7:0] v, output logic en);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
        @(negedge clk);
        v = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [7:0] v;
    logic       en;

    initial begin
        for (int i = 0; i < DEP; i++) exp_mem[i] = 8'h00;
        for (int b = 0; b < NPG; b++) pend_vld[b] = 1'b0;
        pend_page = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dout after reset", dout, 8'h00);
        chk("R1 dout_en after reset", {7'b0, dout_en}, 8'h00);
        for (int a = 0; a < DEP; a++) begin
            read_now(a, v, en);
            chk("R1 array zero after reset", v, 8'h00);
            chk("R2 dout_en on read", {7'b0, en}, 8'h01);
        end
        idle(1);
        chk("R2 dout_en drops without read", {7'b0, dout_en}, 8'h00);

        // R3 R8: fill every page with a full page load
        for (int p = 0; p < NPG; p++) begin
            for (int b = 0; b < NPG; b++) do_write(p * NPG + b, pat(p * NPG + b, 1), 1'b1);
            idle(WIN + CMT + 2);
            apply_pending();
        end
        for (int a = 0; a < DEP; a++) begin
            read_now(a, v, en);
            chk("R3 R8 full page commit", v, exp_mem[a]);
        end

        // R5 R6 R7 R8: timed partial load of page 3, last byte top bit 1
        do_write(3 * NPG + 0, 8'h21, 1'b1);
        do_write(3 * NPG + 2, 8'h9A, 1'b1);          // last accepted strobe at E
        read_now(3 * NPG + 2, v, en);                 // E+2
        chk("R5 old data during load window", v, exp_mem[3 * NPG + 2]);
        idle(WIN - 3);
        read_now(3 * NPG + 2, v, en);                 // E+WIN
        chk("R5 old data at window end", v, exp_mem[3 * NPG + 2]);
        read_now(3 * NPG + 2, v, en);                 // E+WIN+1
        chk("R6 R7 first poll edge", v, 8'h00);
        idle(CMT - 2);
        read_now(3 * NPG + 5, v, en);                 // E+WIN+CMT
        chk("R6 R7 last poll edge", v, 8'h00);
        read_now(3 * NPG + 2, v, en);                 // E+WIN+CMT+1
        apply_pending();
        chk("R6 new data right after commit", v, 8'h9A);
        read_now(3 * NPG + 0, v, en);
        chk("R8 loaded byte committed", v, 8'h21);
        read_now(3 * NPG + 5, v, en);
        chk("R8 unloaded byte kept", v, exp_mem[3 * NPG + 5]);

        // R7 R9: last byte top bit 0, write during commit ignored
        do_write(5 * NPG + 1, 8'hF0, 1'b1);
        do_write(5 * NPG + 2, 8'h35, 1'b1);
        idle(WIN - 1);
        read_now(5 * NPG + 2, v, en);                 // E+WIN+1
        chk("R7 poll inverts last byte top bit", v, 8'h80);
        do_write(9 * NPG + 0, 8'h77, 1'b0);           // during commit
        read_now(0, v, en);
        chk("R9 still polling after ignored strobe", v, 8'h80);
        idle(CMT + WIN + 4);
        apply_pending();
        read_now(9 * NPG + 0, v, en);
        chk("R9 strobe during commit ignored", v, exp_mem[9 * NPG + 0]);
        read_now(5 * NPG + 2, v, en);
        chk("R9 page after commit", v, 8'h35);
        idle(WIN + CMT + 4);
        read_now(9 * NPG + 0, v, en);
        chk("R9 no later commit", v, exp_mem[9 * NPG + 0]);

        // R4: other page ignored, window not restarted
        do_write(7 * NPG + 4, 8'h91, 1'b1);           // E
        do_write(8 * NPG + 4, 8'h22, 1'b0);           // E+2, ignored
        idle(1);
        read_now(7 * NPG + 4, v, en);                 // E+WIN+1
        chk("R4 ignored strobe keeps window and poll bit", v, 8'h00);
        idle(CMT + 2);
        apply_pending();
        read_now(8 * NPG + 4, v, en);
        chk("R4 other page untouched", v, exp_mem[8 * NPG + 4]);
        read_now(7 * NPG + 4, v, en);
        chk("R4 locked page committed", v, 8'h91);

        // R10: same byte loaded twice, later wins
        do_write(10 * NPG + 3, 8'h44, 1'b1);
        do_write(10 * NPG + 3, 8'hC5, 1'b1);
        idle(WIN + CMT + 2);
        apply_pending();
        read_now(10 * NPG + 3, v, en);
        chk("R10 later value committed", v, 8'hC5);

        // R3: held strobe loads first edge only; we_n overrides oe_n
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = AW'(12 * NPG); din = 8'h5A;
        @(negedge clk);
        chk("R3 no read output during write", {7'b0, dout_en}, 8'h00);
        din = 8'hA5;
        @(negedge clk);
        din = 8'h3C;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(WIN + CMT + 2);
        read_now(12 * NPG, v, en);
        exp_mem[12 * NPG] = 8'h5A;
        chk("R3 held strobe loads first data", v, 8'h5A);

        // final sweep of the whole array against the model
        for (int a = 0; a < DEP; a++) begin
            read_now(a, v, en);
            chk("R8 final array contents", v, exp_mem[a]);
        end

        summary();
        $finish;
    end

endmodule